// File: doc/BRIEF.md
# Complementary Dead-Time Gate Controller

This block turns one logic command into two switch enables for a half-bridge. The high-side enable follows the command and the low-side enable follows its inverse. Every change of side passes through an interval, counted in clock cycles, during which both enables are low. This interval is the same length for both directions, so the upper and lower switches never conduct together.

A halt input and two supply-good flags, one for each channel, can take the enables away at any cycle. Whenever a side is released again, the enable for that side waits out a full dead interval before it comes on. The dead interval length is held in an internal count register. A one-cycle write strobe loads it. Reset loads a default of 50 cycles, which is 500 ns at 100 MHz. The register is 10 bits wide, so a count of 500 cycles (5 us at 100 MHz) fits.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: In steady state, `hi_en_o` equals `cmd_i` and `lo_en_o` equals its inverse, as long as halt is low and the relevant supply flag is high.
- R2: When the command changes, the enable that is on goes low on the first clock edge that samples the change. The other enable goes high exactly D edges later, where D is the effective dead count. The delay is the same for rising and falling commands.
- R3: `hi_en_o` and `lo_en_o` are never high in the same cycle.
- R4: While `halt_i` is high, both enables are low, starting from the first edge that samples it.
- R5: A low `hi_supply_ok_i` forces `hi_en_o` low, and a low `lo_supply_ok_i` forces `lo_en_o` low, from the first edge that samples it. The other channel keeps working normally.
- R6: Reset drives both enables low and loads a dead count of 50. A stored count of 0 also means 50.
- R7: A cycle with `dt_we_i` high loads `dt_wdata_i` (10 bits, 1 to 1023 cycles) as the dead count, and every later transition uses it.
- R8: After reset, after halt is released, or after a supply flag recovers, the permitted enable turns on only D edges after the first edge that samples the release.
- R9: A command level held for D or fewer sampled cycles produces no pulse on the enable it would have turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Bridge command: 1 selects the high side, 0 the low side |
| halt_i | input | 1 | Forces both enables off while high |
| dt_we_i | input | 1 | Write strobe for the dead count register |
| dt_wdata_i | input | 10 | Dead count in cycles; 0 selects the default |
| hi_supply_ok_i | input | 1 | High-side supply above its threshold |
| lo_supply_ok_i | input | 1 | Low-side supply above its threshold |
| hi_en_o | output | 1 | High-side switch enable |
| lo_en_o | output | 1 | Low-side switch enable |

## Verification
The hardest case to reach from the ports is a command pulse that ends just before the dead interval runs out. Here the counter is one step from enabling a side when the command returns, and it must restart toward the opposite side without a one-cycle glitch. The bench programs a short count of 10 so it can hold the command for exactly 10 edges. It then watches the high-side enable on every cycle until the low side comes back. The bench also covers halt and supply drops that arrive while an output is on, and counts an exact interval after each release.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_e;

    localparam int unsigned CH_HI = 0;
    localparam int unsigned CH_LO = 1;
    localparam int unsigned N_CH  = 2;
endpackage

// File: rtl/dtg_interval.sv
module dtg_interval #(
    parameter int unsigned DT_W       = 10,
    parameter int unsigned DT_DEFAULT = 50
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [DT_W-1:0] wdata_i,
    output logic [DT_W-1:0] span_o
);
    localparam logic [DT_W-1:0] DEF_V = DT_W'(DT_DEFAULT);

    typedef struct packed {
        logic [DT_W-1:0] cfg;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            s_d.cfg = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cfg <= DEF_V;
        end else begin
            s_q <= s_d;
        end
    end

    // zero is a request for the default length
    assign span_o = (s_q.cfg == '0) ? DEF_V : s_q.cfg;
endmodule

// File: rtl/dtg_demand.sv
module dtg_demand
    import dtg_pkg::*;
(
    input  logic  halt_i,
    input  logic  cmd_i,
    input  logic  hi_ok_i,
    input  logic  lo_ok_i,
    output side_e want_o
);
    logic [N_CH-1:0] ok_v;
    logic [N_CH-1:0] permit;

    assign ok_v = {lo_ok_i, hi_ok_i};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign permit[c] = ok_v[c] & ~halt_i;
    end

    always_comb begin
        want_o = SIDE_NONE;
        if (cmd_i) begin
            if (permit[CH_HI]) want_o = SIDE_HI;
        end else begin
            if (permit[CH_LO]) want_o = SIDE_LO;
        end
    end
endmodule

// File: rtl/dtg_sequencer.sv
module dtg_sequencer
    import dtg_pkg::*;
#(
    parameter int unsigned DT_W = 10
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  side_e           want_i,
    input  logic [DT_W-1:0] span_i,
    output logic            hi_o,
    output logic            lo_o
);
    localparam int unsigned CW = DT_W + 1;

    typedef struct packed {
        side_e           side;
        side_e           tgt;
        logic [DT_W-1:0] cnt;
        logic            hi;
        logic            lo;
    } seq_t;

    seq_t s_d, s_q;
    logic [CW-1:0] next_cnt;
    logic          ripe;

    assign next_cnt = {1'b0, s_q.cnt} + CW'(1);
    assign ripe     = next_cnt >= {1'b0, span_i};

    always_comb begin
        s_d = s_q;
        if (s_q.side != SIDE_NONE) begin
            // turn-off is immediate; start the gap toward the new wish
            if (want_i != s_q.side) begin
                s_d.side = SIDE_NONE;
                s_d.tgt  = want_i;
                s_d.cnt  = '0;
            end
        end else if (want_i != s_q.tgt) begin
            s_d.tgt = want_i;
            s_d.cnt = '0;
        end else if (want_i == SIDE_NONE) begin
            s_d.cnt = '0;
        end else if (ripe) begin
            s_d.side = want_i;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = next_cnt[DT_W-1:0];
        end
        s_d.hi = (s_d.side == SIDE_HI);
        s_d.lo = (s_d.side == SIDE_LO);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{side: SIDE_NONE, tgt: SIDE_NONE, cnt: '0, hi: 1'b0, lo: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hi_o = s_q.hi;
    assign lo_o = s_q.lo;
endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl
    import dtg_pkg::*;
#(
    parameter int unsigned DT_W       = 10,
    parameter int unsigned DT_DEFAULT = 50
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cmd_i,
    input  logic            halt_i,
    input  logic            dt_we_i,
    input  logic [DT_W-1:0] dt_wdata_i,
    input  logic            hi_supply_ok_i,
    input  logic            lo_supply_ok_i,
    output logic            hi_en_o,
    output logic            lo_en_o
);
    side_e           want;
    logic [DT_W-1:0] span;

    dtg_interval #(.DT_W(DT_W), .DT_DEFAULT(DT_DEFAULT)) u_interval (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (dt_we_i),
        .wdata_i (dt_wdata_i),
        .span_o  (span)
    );

    dtg_demand u_demand (
        .halt_i  (halt_i),
        .cmd_i   (cmd_i),
        .hi_ok_i (hi_supply_ok_i),
        .lo_ok_i (lo_supply_ok_i),
        .want_o  (want)
    );

    dtg_sequencer #(.DT_W(DT_W)) u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .want_i (want),
        .span_i (span),
        .hi_o   (hi_en_o),
        .lo_o   (lo_en_o)
    );
endmodule

// File: rtl/deadtime_gate_ctrl_chk.sv
module deadtime_gate_ctrl_chk #(
    parameter int unsigned DT_W       = 10,
    parameter int unsigned DT_DEFAULT = 50
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            cmd_i,
    input logic            halt_i,
    input logic            dt_we_i,
    input logic [DT_W-1:0] dt_wdata_i,
    input logic            hi_supply_ok_i,
    input logic            lo_supply_ok_i,
    input logic            hi_en_o,
    input logic            lo_en_o
);
    localparam int unsigned RW = DT_W + 1;

    logic [DT_W-1:0] cfg_m;
    logic [DT_W-1:0] eff_m;
    logic [RW-1:0]   off_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_m <= DT_W'(DT_DEFAULT);
        else if (dt_we_i) cfg_m <= dt_wdata_i;
    end
    assign eff_m = (cfg_m == '0) ? DT_W'(DT_DEFAULT) : cfg_m;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) off_run_q <= '0;
        else if (hi_en_o || lo_en_o) off_run_q <= '0;
        else if (off_run_q != '1) off_run_q <= off_run_q + RW'(1);
    end

    AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hi_en_o && lo_en_o));                                          // R3
    AST_HALT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_i |=> (!hi_en_o && !lo_en_o));                              // R4
    AST_HI_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hi_supply_ok_i |=> !hi_en_o);                                   // R5
    AST_LO_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lo_supply_ok_i |=> !lo_en_o);                                   // R5
    AST_HI_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hi_en_o) |-> $past(cmd_i));                                // R1
    AST_LO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lo_en_o) |-> !$past(cmd_i));                               // R1
    AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(hi_en_o) || $rose(lo_en_o)) |->
            (off_run_q >= {1'b0, $past(eff_m)}));                        // R2
endmodule

bind deadtime_gate_ctrl deadtime_gate_ctrl_chk #(
    .DT_W(DT_W), .DT_DEFAULT(DT_DEFAULT)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_i          (cmd_i),
    .halt_i         (halt_i),
    .dt_we_i        (dt_we_i),
    .dt_wdata_i     (dt_wdata_i),
    .hi_supply_ok_i (hi_supply_ok_i),
    .lo_supply_ok_i (lo_supply_ok_i),
    .hi_en_o        (hi_en_o),
    .lo_en_o        (lo_en_o)
);

// File: tb/deadtime_gate_ctrl_test.sv
`timescale 1ns/1ps
module deadtime_gate_ctrl_test;
    localparam int DW = 10;
    localparam int DEF = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd = 1'b0;
    logic          halt = 1'b0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          hi_ok = 1'b1;
    logic          lo_ok = 1'b1;
    logic          ho, lo;

    int n_chk = 0;
    int n_bad = 0;
    int overlap = 0;
    bit done = 0;

    always #2 clk = ~clk;

    deadtime_gate_ctrl #(.DT_W(DW), .DT_DEFAULT(DEF)) uut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .halt_i(halt),
        .dt_we_i(we), .dt_wdata_i(wdata),
        .hi_supply_ok_i(hi_ok), .lo_supply_ok_i(lo_ok),
        .hi_en_o(ho), .lo_en_o(lo)
    );

    always @(negedge clk) if (rst_n && ho && lo) overlap++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pair(input logic eh, input logic el, input string tag);
        n_chk++;
        if (ho !== eh || lo !== el) begin
            n_bad++;
            $display("FAIL %s: ho/lo actual=%b%b expected=%b%b", tag, ho, lo, eh, el);
        end
    endtask

    task automatic set_dt(input int v);
        we = 1'b1; wdata = DW'(v);
        step(1);
        we = 1'b0;
    endtask

    // drive a new command and time the swap
    task automatic t_edge(input logic dir, input int d, input string tag);
        cmd = dir;
        step(1);     pair(1'b0, 1'b0, {tag, " R2 off at first edge"});
        step(d - 1); pair(1'b0, 1'b0, {tag, " R2 still dead"});
        step(1);     pair(dir, ~dir, {tag, " R2 on after gap"});
        step(3);     pair(dir, ~dir, {tag, " R1 steady"});
    endtask

    task automatic t_reset;
        step(3);
        pair(1'b0, 1'b0, "R6 in reset");
        rst_n = 1'b1;
        step(DEF);   pair(1'b0, 1'b0, "R8 after reset still dead");
        step(1);     pair(1'b0, 1'b1, "R6 R8 default interval from reset");
        step(4);     pair(1'b0, 1'b1, "R1 low side steady");
    endtask

    task automatic t_prog;
        set_dt(10);
        t_edge(1'b1, 10, "R7 count 10 rise");
        t_edge(1'b0, 10, "R7 count 10 fall");
        set_dt(0);
        t_edge(1'b1, DEF, "R6 zero means default");
        set_dt(500);
        t_edge(1'b0, 500, "R7 count 500");
    endtask

    task automatic t_short;
        int glitch = 0;
        set_dt(10);
        cmd = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (ho) glitch++;
        end
        cmd = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (ho) glitch++;
        end
        n_chk++;
        if (glitch != 0) begin
            n_bad++;
            $display("FAIL R9: short pulse ho high cycles actual=%0d expected=0", glitch);
        end
        pair(1'b0, 1'b0, "R9 low side waits full gap");
        step(1); pair(1'b0, 1'b1, "R9 low side back");
    endtask

    task automatic t_halt;
        cmd = 1'b1;
        step(12); pair(1'b1, 1'b0, "R1 high side on");
        halt = 1'b1;
        step(1);  pair(1'b0, 1'b0, "R4 halt immediate");
        step(20); pair(1'b0, 1'b0, "R4 halt held");
        halt = 1'b0;
        step(10); pair(1'b0, 1'b0, "R8 halt release gap");
        step(1);  pair(1'b1, 1'b0, "R8 halt release on");
    endtask

    task automatic t_uv;
        hi_ok = 1'b0;
        step(1);  pair(1'b0, 1'b0, "R5 hi supply drop");
        step(15); pair(1'b0, 1'b0, "R5 hi held off");
        cmd = 1'b0;
        step(10); pair(1'b0, 1'b0, "R5 low side gap");
        step(1);  pair(1'b0, 1'b1, "R5 low side unaffected");
        lo_ok = 1'b0;
        step(1);  pair(1'b0, 1'b0, "R5 lo supply drop");
        step(5);
        lo_ok = 1'b1;
        step(10); pair(1'b0, 1'b0, "R8 lo supply recover gap");
        step(1);  pair(1'b0, 1'b1, "R8 lo supply recover on");
        hi_ok = 1'b1;
        t_edge(1'b1, 10, "R2 after supplies restored");
    endtask

    initial begin
        t_reset();
        t_edge(1'b1, DEF, "R2 default rise");
        t_edge(1'b0, DEF, "R2 default fall");
        t_prog();
        t_short();
        t_halt();
        t_uv();
        n_chk++;
        if (overlap != 0) begin
            n_bad++;
            $display("FAIL R3: overlap cycles actual=%0d expected=0", overlap);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule